// File: doc/BRIEF.md
# Next Free Entry Tracker

This block sits beside an associative lookup table and keeps one occupancy bit for every narrow location of that table. The host's write and learn commands carry the target address and the least significant bit of the stored word. The tracker copies that bit into its occupancy vector, so a 1 marks a location as occupied and a 0 marks it as empty. From the vector it keeps a registered copy of the lowest empty address and a flag that says the table has no empty entry left. The host uses these two outputs to pick where the next learned entry goes.

The table runs in one of two organizations. In narrow mode every location is its own entry. In double-width mode two neighbouring locations, 2k and 2k+1, form one entry. Such an entry carries two occupancy bits, which must agree. The block finds the empty entry with a balanced binary priority tree over the occupancy vector, and it uses a second tree over the pair vector in double-width mode. The result is registered, so it is valid one clock after the command that caused it. A busy output covers that gap. ENTRIES must be a power of two and at least 4.

Top module: `next_free_tracker`

## Requirements
- R1: While reset is high and in the cycle after it is released, next_free is 0 and full, busy and pair_err are 0. Every location reads as empty afterwards.
- R2: In narrow mode (mode_wide = 0), a command sets the occupancy of location cmd_addr to cmd_occ_lo. next_free is the lowest location whose occupancy is 0.
- R3: full is 1 exactly when the current mode has no empty entry. next_free reads 0 while full is 1.
- R4: In double-width mode (mode_wide = 1), a command writes both locations of pair cmd_addr>>1. cmd_addr bit 0 is ignored. A pair counts as empty only when both of its bits are 0. next_free is twice the lowest empty pair index, so its bit 0 is always 0.
- R5: A command sampled at clock edge E raises busy for the cycle after E. next_free and full include that command from edge E+1, where busy returns low if no new command came at E. Back-to-back commands keep busy high.
- R6: In double-width mode, a command whose cmd_occ_lo and cmd_occ_hi differ sets pair_err at the same edge. Both locations of that pair are then stored as occupied.
- R7: pair_err stays 1 until reset.
- R8: With no command for two edges and mode_wide held steady, next_free and full do not change.
- R9: In narrow mode cmd_occ_hi has no effect: it changes neither the stored occupancy nor pair_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wide | input | 1 | 0 = narrow entries, 1 = double-width entries |
| cmd_valid | input | 1 | A write or learn command is present this cycle |
| cmd_addr | input | $clog2(ENTRIES) | Narrow location address of the command |
| cmd_occ_lo | input | 1 | Bit 0 of the written word (occupancy of the low half) |
| cmd_occ_hi | input | 1 | Occupancy bit of the upper half, used only in double-width mode |
| next_free | output | $clog2(ENTRIES) | Lowest empty narrow address (0 when full) |
| full | output | 1 | No empty entry exists in the current mode |
| busy | output | 1 | next_free and full do not yet reflect the last command |
| pair_err | output | 1 | Sticky flag: a double-width write carried disagreeing occupancy bits |

## Verification
The search register can update in the same edge that accepts a new command. The bench provokes this with back-to-back commands. It checks that busy stays high across both commands and that the result settled afterwards includes both writes. A second overlap is an illegal double-width pair that lands on the last empty pair. That single edge must raise pair_err and also drive full high one edge later. The bench judges both cases against its own occupancy model.

// File: rtl/nft_pkg.sv
package nft_pkg;

  typedef enum logic {
    MODE_NARROW = 1'b0,
    MODE_WIDE   = 1'b1
  } nft_mode_e;

  typedef struct packed {
    logic      en;
    nft_mode_e mode;
    logic      lo;
    logic      hi;
  } nft_wr_t;

endpackage

// File: rtl/nft_occ_store.sv
module nft_occ_store #(
  parameter int ENTRIES = 64,
  localparam int AW = $clog2(ENTRIES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  nft_pkg::nft_wr_t     wr,
  input  logic [AW-1:0]        wr_addr,
  output logic [ENTRIES-1:0]   occ,
  output logic                 mix_err
);
  import nft_pkg::*;

  logic          wide_val;
  logic [AW-1:0] even_addr;
  logic [AW-1:0] odd_addr;

  always_comb begin
    wide_val  = wr.lo | wr.hi;
    even_addr = {wr_addr[AW-1:1], 1'b0};
    odd_addr  = {wr_addr[AW-1:1], 1'b1};
    mix_err   = wr.en & (wr.mode == MODE_WIDE) & (wr.lo ^ wr.hi);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      occ <= '0;
    end else if (wr.en) begin
      if (wr.mode == MODE_WIDE) begin
        occ[even_addr] <= wide_val;
        occ[odd_addr]  <= wide_val;
      end else begin
        occ[wr_addr] <= wr.lo;
      end
    end
  end

endmodule

// File: rtl/nft_first_free.sv
module nft_first_free #(
  parameter int N = 64,
  localparam int W = $clog2(N),
  localparam int NODES = 2 * N - 1
) (
  input  logic [N-1:0] taken,
  output logic         found,
  output logic [W-1:0] idx
);

  logic         nv [NODES];
  logic [W-1:0] ni [NODES];

  for (genvar i = 0; i < N; i++) begin : g_leaf
    assign nv[N-1+i] = ~taken[i];
    assign ni[N-1+i] = W'(i);
  end

  for (genvar j = 0; j < N - 1; j++) begin : g_node
    assign nv[j] = nv[2*j+1] | nv[2*j+2];
    assign ni[j] = nv[2*j+1] ? ni[2*j+1] : ni[2*j+2];
  end

  assign found = nv[0];
  assign idx   = ni[0];

endmodule

// File: rtl/next_free_tracker.sv
module next_free_tracker #(
  parameter int ENTRIES = 64,
  localparam int AW = $clog2(ENTRIES),
  localparam int PAIRS = ENTRIES / 2,
  localparam int PW = AW - 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode_wide,
  input  logic          cmd_valid,
  input  logic [AW-1:0] cmd_addr,
  input  logic          cmd_occ_lo,
  input  logic          cmd_occ_hi,
  output logic [AW-1:0] next_free,
  output logic          full,
  output logic          busy,
  output logic          pair_err
);
  import nft_pkg::*;

  nft_wr_t            wr;
  logic [ENTRIES-1:0] occ;
  logic [PAIRS-1:0]   pair_occ;
  logic               mix_err;
  logic               n_found;
  logic [AW-1:0]      n_idx;
  logic               w_found;
  logic [PW-1:0]      w_idx;

  always_comb begin
    wr.en   = cmd_valid;
    wr.mode = mode_wide ? MODE_WIDE : MODE_NARROW;
    wr.lo   = cmd_occ_lo;
    wr.hi   = cmd_occ_hi;
  end

  nft_occ_store #(.ENTRIES(ENTRIES)) u_store (
    .clk     (clk),
    .rst     (rst),
    .wr      (wr),
    .wr_addr (cmd_addr),
    .occ     (occ),
    .mix_err (mix_err)
  );

  for (genvar k = 0; k < PAIRS; k++) begin : g_pair
    assign pair_occ[k] = occ[2*k] | occ[2*k+1];
  end

  nft_first_free #(.N(ENTRIES)) u_narrow (
    .taken (occ),
    .found (n_found),
    .idx   (n_idx)
  );

  nft_first_free #(.N(PAIRS)) u_wide (
    .taken (pair_occ),
    .found (w_found),
    .idx   (w_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      next_free <= '0;
      full      <= 1'b0;
      busy      <= 1'b0;
      pair_err  <= 1'b0;
    end else begin
      busy <= cmd_valid;
      if (mix_err) pair_err <= 1'b1;
      if (wr.mode == MODE_WIDE) begin
        full      <= ~w_found;
        next_free <= w_found ? {w_idx, 1'b0} : '0;
      end else begin
        full      <= ~n_found;
        next_free <= n_found ? n_idx : '0;
      end
    end
  end

endmodule

// File: rtl/nft_checker.sv
module nft_checker #(
  parameter int ENTRIES = 64,
  localparam int AW = $clog2(ENTRIES)
) (
  input logic          clk,
  input logic          rst,
  input logic          mode_wide,
  input logic          cmd_valid,
  input logic [AW-1:0] cmd_addr,
  input logic          cmd_occ_lo,
  input logic          cmd_occ_hi,
  input logic [AW-1:0] next_free,
  input logic          full,
  input logic          busy,
  input logic          pair_err
);

  AST_BUSY_AFTER_CMD: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> busy); // R5

  AST_IDLE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> !busy); // R5

  AST_WIDE_EVEN_ADDR: assert property (@(posedge clk) disable iff (rst)
    $past(mode_wide) |-> (next_free[0] == 1'b0)); // R4

  AST_FULL_ADDR_ZERO: assert property (@(posedge clk) disable iff (rst)
    full |-> (next_free == '0)); // R3

  AST_MIX_SETS_ERR: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && mode_wide && (cmd_occ_lo != cmd_occ_hi)) |=> pair_err); // R6

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    pair_err |=> pair_err); // R7

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!cmd_valid && !busy && $stable(mode_wide)) |=> ($stable(next_free) && $stable(full))); // R8

  AST_NARROW_NO_ERR: assert property (@(posedge clk) disable iff (rst)
    (!pair_err && (!cmd_valid || !mode_wide)) |=> !pair_err); // R9

endmodule

bind next_free_tracker nft_checker #(.ENTRIES(ENTRIES)) u_chk (.*);

// File: tb/sim_next_free_tracker.sv
`timescale 1ns/1ps
module sim_next_free_tracker;
  localparam int ENT = 64;
  localparam int AW = $clog2(ENT);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          mode_wide = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic          cmd_occ_lo = 1'b0;
  logic          cmd_occ_hi = 1'b0;
  logic [AW-1:0] next_free;
  logic          full;
  logic          busy;
  logic          pair_err;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done = 1'b0;
  bit  m_occ [ENT];
  bit  m_err = 1'b0;

  always #4 clk = ~clk;

  next_free_tracker #(.ENTRIES(ENT)) u0 (
    .clk(clk), .rst(rst), .mode_wide(mode_wide), .cmd_valid(cmd_valid),
    .cmd_addr(cmd_addr), .cmd_occ_lo(cmd_occ_lo), .cmd_occ_hi(cmd_occ_hi),
    .next_free(next_free), .full(full), .busy(busy), .pair_err(pair_err)
  );

  function automatic int exp_nf(bit wide);
    int r = 0;
    if (wide) begin
      for (int k = ENT/2 - 1; k >= 0; k--)
        if (!(m_occ[2*k] | m_occ[2*k+1])) r = 2*k;
    end else begin
      for (int i = ENT - 1; i >= 0; i--)
        if (!m_occ[i]) r = i;
    end
    return r;
  endfunction

  function automatic bit exp_full(bit wide);
    bit f = 1'b1;
    if (wide) begin
      for (int k = 0; k < ENT/2; k++)
        if (!(m_occ[2*k] | m_occ[2*k+1])) f = 1'b0;
    end else begin
      for (int i = 0; i < ENT; i++)
        if (!m_occ[i]) f = 1'b0;
    end
    return f;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_write(input int addr, input bit lo, input bit hi);
    if (mode_wide) begin
      int b = addr & ~1;
      m_occ[b]   = lo | hi;
      m_occ[b+1] = lo | hi;
      if (lo != hi) m_err = 1'b1;
    end else begin
      m_occ[addr] = lo;
    end
  endtask

  task automatic check_outputs(input string req);
    chk({req, " busy"}, int'(busy), 0);
    chk({req, " next_free"}, int'(next_free), exp_nf(mode_wide));
    chk({req, " full"}, int'(full), int'(exp_full(mode_wide)));
    chk({req, " pair_err"}, int'(pair_err), int'(m_err));
  endtask

  task automatic drive(input int addr, input bit lo, input bit hi);
    cmd_valid  = 1'b1;
    cmd_addr   = AW'(addr);
    cmd_occ_lo = lo;
    cmd_occ_hi = hi;
  endtask

  task automatic apply(input int addr, input bit lo, input bit hi, input string req);
    @(negedge clk);
    drive(addr, lo, hi);
    @(posedge clk);
    model_write(addr, lo, hi);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R5 busy after command", int'(busy), 1);
    @(negedge clk);
    check_outputs(req);
  endtask

  task automatic apply_pair(input int a1, input bit l1, input int a2, input bit l2);
    @(negedge clk);
    drive(a1, l1, l1);
    @(posedge clk);
    model_write(a1, l1, l1);
    @(negedge clk);
    drive(a2, l2, l2);
    @(posedge clk);
    model_write(a2, l2, l2);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R5 busy held back-to-back", int'(busy), 1);
    @(negedge clk);
    check_outputs("R5 back-to-back result");
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 busy in reset", int'(busy), 0);
    chk("R1 pair_err in reset", int'(pair_err), 0);
    rst = 1'b0;
    for (int i = 0; i < ENT; i++) m_occ[i] = 1'b0;
    m_err = 1'b0;
    chk("R1 next_free", int'(next_free), 0);
    chk("R1 full", int'(full), 0);
    @(negedge clk);
    check_outputs("R1 after release");
  endtask

  task automatic idle_check(input string req);
    logic [AW-1:0] nf0;
    logic          f0;
    @(negedge clk);
    nf0 = next_free;
    f0  = full;
    repeat (5) @(negedge clk);
    chk({req, " next_free stable"}, int'(next_free), int'(nf0));
    chk({req, " full stable"}, int'(full), int'(f0));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0123));
    do_reset();

    // Narrow fill, R2 then R3 when the last one lands
    for (int i = 0; i < ENT; i++) apply(i, 1'b1, 1'(i & 1), "R2 narrow fill");
    chk("R3 full after fill", int'(full), 1);
    chk("R3 next_free zero when full", int'(next_free), 0);
    apply(37, 1'b0, 1'b0, "R2 free 37");
    chk("R2 next_free 37", int'(next_free), 37);
    apply(5, 1'b0, 1'b1, "R9 hi ignored narrow");
    chk("R9 next_free 5", int'(next_free), 5);
    chk("R9 no pair_err", int'(pair_err), 0);
    apply(5, 1'b1, 1'b0, "R2 reoccupy 5");
    chk("R2 next_free back to 37", int'(next_free), 37);
    idle_check("R8 narrow idle");
    apply_pair(37, 1'b1, 0, 1'b0);

    // Random narrow traffic
    for (int n = 0; n < 300; n++)
      apply(int'($urandom_range(ENT-1)), 1'($urandom_range(1)), 1'($urandom_range(1)), "R2 random narrow");

    do_reset();
    mode_wide = 1'b1;
    apply(1, 1'b1, 1'b1, "R4 wide odd addr");
    chk("R4 next_free even 2", int'(next_free), 2);
    apply(3, 1'b1, 1'b1, "R4 wide second");
    chk("R4 next_free 4", int'(next_free), 4);
    apply(4, 1'b1, 1'b0, "R6 mixed pair");
    chk("R6 pair_err set", int'(pair_err), 1);
    chk("R6 mixed pair occupied", int'(next_free), 6);
    apply(0, 1'b0, 1'b0, "R7 legal after error");
    chk("R7 pair_err sticky", int'(pair_err), 1);
    chk("R4 pair 0 free", int'(next_free), 0);

    for (int n = 0; n < 300; n++) begin
      bit lo = 1'($urandom_range(1));
      bit hi = ($urandom_range(7) == 0) ? ~lo : lo;
      apply(int'($urandom_range(ENT-1)), lo, hi, "R4 random wide");
    end

    // Fill every pair, last one with a mixed pattern
    for (int k = 0; k < ENT/2 - 1; k++) apply(2*k, 1'b1, 1'b1, "R4 wide fill");
    apply(ENT-1, 1'b0, 1'b1, "R6 mixed on last pair");
    chk("R3 wide full", int'(full), 1);
    chk("R6 err with full", int'(pair_err), 1);
    idle_check("R8 wide idle");
    apply_pair(10, 1'b0, 20, 1'b0);
    chk("R5 back-to-back lowest 10", int'(next_free), 10);

    do_reset();
    chk("R7 pair_err cleared by reset", int'(pair_err), 0);
    mode_wide = 1'b0;
    apply(0, 1'b1, 1'b1, "R9 narrow hi no err");
    chk("R9 pair_err stays 0", int'(pair_err), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule